// File: doc/BRIEF.md
# Card Command and Block Transfer Controller

This controller sits between a processor's register bus and a byte-wide link to a removable card. Software loads a 16-byte command into four buffer words. It sets a block count and a block size code, then writes the control register with its start bit set. The controller sends the command bytes over the card link, one byte per cycle. It waits a programmable number of idle cycles and then moves the data phase one 32-bit word at a time through a single-word FIFO port. In read mode it assembles card bytes into words for the processor to pop. In write mode it sends words that the processor has pushed. A data-ready flag tells software when the FIFO port may be accessed.

The start bit reads as busy until the final block is done and then clears by itself. An optional one-cycle interrupt marks the end of the transfer. A card reset output can be raised once and then stays high until the controller itself is reset. A security-control register captures a key index and a seed value into output latches, which feed a cipher engine outside this block. A CRC status input is reflected in the control register.

Word addresses: 0 control, 1 block count, 2 security control, 3 seed, 4 to 7 command buffer slots 0 to 3, 8 FIFO port. Reads return data one cycle after the read strobe.

Top module: `cardcmd_ctrl`

## Requirements
- R1: A control write with bit 31 set, while idle, starts a transfer. In the cycle after that write, `card_strobe` goes high for 16 consecutive cycles carrying the command: slot 0 first, then slots 1, 2, 3. Within each slot the byte in bits 31:24 goes first and bits 7:0 go last.
- R2: Control bits 19:16 are the size code. Codes 0..8 give 0, 4, 16, 64, 512, 1024, 2048, 4096 and 16384 bytes per block. Codes 9..15 give 0 bytes.
- R3: Block count bits 15:0 hold the number of read blocks minus one. Bits 31:16 hold the number of write blocks minus one. Control bit 29 selects the direction (1 write, 0 read) and therefore which half is used.
- R4: Control bits 26:24 set the delay d. Exactly d idle cycles separate the last command byte from the first data byte. A written value above 5 is stored as 5.
- R5: In read mode, `card_din` is sampled at the clock edge that ends each strobe cycle. Four such bytes form one FIFO word, with the first byte in bits 31:24.
- R6: In write mode, each pushed FIFO word is sent as four strobed bytes, bits 31:24 first.
- R7: Control bit 27 (data ready) reads 1 when idle. While busy it reads 1 only when the FIFO port holds a word to pop (read mode) or has room for a push (write mode).
- R8: Control bit 31 reads 1 until the last data byte of the last block has been transferred, then 0. With a zero-byte size code the transfer ends after the command bytes.
- R9: With control bit 30 set, `irq` is high for exactly one cycle at the end of each transfer. With bit 30 clear it stays low.
- R10: Writing 1 to control bit 28 raises `card_rst`. Later writes cannot lower it; only `rst` clears it.
- R11: A security-control write with bit 2 set copies its bits 9:8 to `key_idx`. One with bit 15 set copies the seed register (address 3) to `seed_out`. Writes without these bits leave the latches unchanged.
- R12: Control bit 4 reads the level of `crc_err`.
- R13: While busy, control writes change neither size, delay, direction nor interrupt enable. Only the reset bit can still be raised.
- R14: After reset, the control register reads 32'h0800_0000, and `card_strobe`, `irq` and `card_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO port when it is addressed) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| crc_err | input | 1 | CRC error level from outside checker |
| irq | output | 1 | End-of-transfer pulse |
| card_dout | output | 8 | Byte to the card (command and write data) |
| card_din | input | 8 | Byte from the card (read data) |
| card_strobe | output | 1 | One byte transferred this cycle |
| card_wr | output | 1 | Data direction to the card, 1 = controller drives data |
| card_rst | output | 1 | Card reset level |
| key_idx | output | 2 | Latched key index |
| seed_out | output | 32 | Latched seed |

## Verification
Register reads are compared one cycle after the read strobe. Card bytes are recorded by a monitor that stamps each strobe cycle. Command bytes are due from the cycle after the start write. The first data byte is due d+1 cycles after the last command byte, so the checks compare cycle stamps instead of waiting fixed delays. Read data is predicted from the card model's byte counter: each byte is the count of strobes seen so far. `irq`, `card_rst` and the key and seed latches are sampled at the falling edge after the write that should change them.

// File: rtl/cardcmd_pkg.sv
package cardcmd_pkg;
  localparam int ADDR_W    = 4;
  localparam int CMD_WORDS = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_BLK  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SEED = 4'd3;
  localparam logic [ADDR_W-1:0] A_FIFO = 4'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_GAP, ST_DATA} eng_state_t;

  // words of 32 bits per block for each size code
  function automatic int code_words(input logic [3:0] code);
    case (code)
      4'd1: return 1;
      4'd2: return 4;
      4'd3: return 16;
      4'd4: return 128;
      4'd5: return 256;
      4'd6: return 512;
      4'd7: return 1024;
      4'd8: return 4096;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/cardcmd_sizedec.sv
module cardcmd_sizedec #(
  parameter int WPB_W = 13
) (
  input  logic [3:0]       code,
  output logic [WPB_W-1:0] wpb
);
  import cardcmd_pkg::*;
  always_comb wpb = WPB_W'(code_words(code));
endmodule

// File: rtl/cardcmd_regs.sv
module cardcmd_regs
  import cardcmd_pkg::*;
#(
  parameter int MAX_DELAY = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  input  logic                    busy,
  input  logic                    ready,
  input  logic                    crc_err,
  input  logic [31:0]             hold,
  output logic [31:0]             rdata,
  output logic [3:0]              size_code,
  output logic [2:0]              dly,
  output logic                    dir,
  output logic                    ie,
  output logic                    crst,
  output logic [31:0]             blk,
  output logic [CMD_WORDS*32-1:0] cmd_flat,
  output logic [1:0]              key_idx,
  output logic [31:0]             seed_out,
  output logic                    start,
  output logic                    push,
  output logic                    pop
);
  localparam logic [2:0] DMAX = 3'(MAX_DELAY);
  logic [31:0] seed_q;
  logic        ctrl_wr;

  assign ctrl_wr = wr && (addr == A_CTRL);
  assign start   = ctrl_wr && wdata[31] && !busy;
  assign push    = wr && (addr == A_FIFO);
  assign pop     = rd && (addr == A_FIFO);

  always_ff @(posedge clk) begin
    if (rst) begin
      size_code <= '0; dly <= '0; dir <= 1'b0; ie <= 1'b0; crst <= 1'b0;
      blk <= '0; cmd_flat <= '0; key_idx <= '0; seed_out <= '0; seed_q <= '0;
      rdata <= '0;
    end else begin
      if (ctrl_wr) begin
        crst <= crst | wdata[28];
        if (!busy) begin
          size_code <= wdata[19:16];
          dly       <= (wdata[26:24] > DMAX) ? DMAX : wdata[26:24];
          dir       <= wdata[29];
          ie        <= wdata[30];
        end
      end
      if (wr && addr == A_BLK)  blk <= wdata;
      if (wr && addr == A_SEED) seed_q <= wdata;
      if (wr && addr == A_SEC) begin
        if (wdata[2])  key_idx  <= wdata[9:8];
        if (wdata[15]) seed_out <= seed_q;
      end
      if (wr && addr[3:2] == 2'b01) cmd_flat[{addr[1:0], 5'b0} +: 32] <= wdata;
      if (rd) begin
        if (addr[3:2] == 2'b01) rdata <= cmd_flat[{addr[1:0], 5'b0} +: 32];
        else case (addr)
          A_CTRL: rdata <= {busy, ie, dir, crst, ready, dly, 4'b0, size_code,
                            11'b0, crc_err, 4'b0};
          A_BLK:  rdata <= blk;
          A_SEC:  rdata <= {22'b0, key_idx, 8'b0};
          A_SEED: rdata <= seed_q;
          A_FIFO: rdata <= hold;
          default: rdata <= '0;
        endcase
      end
    end
  end

  // R10
  crst_sticky_chk: assert property (@(posedge clk) disable iff (rst) crst |=> crst);
  // R4
  delay_range_chk: assert property (@(posedge clk) disable iff (rst) dly <= DMAX);
  // R13
  busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(size_code) && $stable(dir)));
endmodule

// File: rtl/cardcmd_engine.sv
module cardcmd_engine
  import cardcmd_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int WPB_W     = 13,
  parameter int MAX_DELAY = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    dir,
  input  logic [2:0]              dly,
  input  logic                    ie,
  input  logic [WPB_W-1:0]        wpb,
  input  logic [CNT_W-1:0]        blocks_m1,
  input  logic [CMD_WORDS*32-1:0] cmd_flat,
  input  logic                    push,
  input  logic                    pop,
  input  logic [31:0]             wdata,
  input  logic [7:0]              card_din,
  output logic                    busy,
  output logic                    ready,
  output logic [31:0]             hold,
  output logic [7:0]              card_dout,
  output logic                    card_strobe,
  output logic                    irq
);
  localparam int CIDX_W = $clog2(CMD_WORDS * 4);
  localparam logic [2:0] DMAX = 3'(MAX_DELAY);

  eng_state_t        st;
  logic [CIDX_W-1:0] cidx;
  logic [2:0]        dcnt, bidx;
  logic [WPB_W-1:0]  wcnt, wpb_m1;
  logic [CNT_W-1:0]  bcnt;
  logic [23:0]       shift;
  logic              full, last_word;
  logic [31:0]       cmd_word, cmd_rot, hold_rot;

  assign wpb_m1    = wpb - 1'b1;
  assign last_word = (wcnt == wpb_m1) && (bcnt == blocks_m1);
  assign cmd_word  = cmd_flat[{cidx[CIDX_W-1:2], 5'b0} +: 32];
  assign cmd_rot   = cmd_word << {cidx[1:0], 3'b000};
  assign hold_rot  = hold << {bidx[1:0], 3'b000};
  assign ready     = !busy || (dir ? !full : full);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cidx <= '0; dcnt <= '0; bidx <= '0; wcnt <= '0; bcnt <= '0;
      shift <= '0; full <= 1'b0; hold <= '0; busy <= 1'b0;
      card_dout <= '0; card_strobe <= 1'b0; irq <= 1'b0;
    end else begin
      irq         <= 1'b0;
      card_strobe <= 1'b0;
      if (card_strobe && !dir) shift <= {shift[15:0], card_din};
      if (push && dir && !full) begin hold <= wdata; full <= 1'b1; end
      if (pop && !dir && full) full <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st <= ST_CMD; busy <= 1'b1;
          cidx <= '0; bidx <= '0; wcnt <= '0; bcnt <= '0;
        end
        ST_CMD: begin
          card_strobe <= 1'b1;
          card_dout   <= cmd_rot[31:24];
          cidx        <= cidx + 1'b1;
          if (&cidx) begin
            if (wpb == '0) begin st <= ST_IDLE; busy <= 1'b0; irq <= ie; end
            else if (dly == '0) st <= ST_DATA;
            else begin st <= ST_GAP; dcnt <= dly - 1'b1; end
          end
        end
        ST_GAP: if (dcnt == '0) st <= ST_DATA; else dcnt <= dcnt - 1'b1;
        default: begin
          if (dir) begin
            if (full) begin
              card_strobe <= 1'b1;
              card_dout   <= hold_rot[31:24];
              bidx        <= bidx + 1'b1;
              if (bidx == 3'd3) begin
                full <= 1'b0; bidx <= '0;
                if (last_word) begin st <= ST_IDLE; busy <= 1'b0; irq <= ie; end
                else if (wcnt == wpb_m1) begin wcnt <= '0; bcnt <= bcnt + 1'b1; end
                else wcnt <= wcnt + 1'b1;
              end
            end
          end else if (bidx == 3'd4) begin
            hold <= {shift, card_din}; full <= 1'b1; bidx <= '0;
            if (last_word) begin st <= ST_IDLE; busy <= 1'b0; irq <= ie; end
            else if (wcnt == wpb_m1) begin wcnt <= '0; bcnt <= bcnt + 1'b1; end
            else wcnt <= wcnt + 1'b1;
          end else if (bidx != '0 || !full) begin
            card_strobe <= 1'b1;
            bidx        <= bidx + 1'b1;
          end
        end
      endcase
    end
  end

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
  // R8
  irq_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && $past(busy)));
  // R4
  gap_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GAP) |-> (dcnt < DMAX));
  // R5
  word_room_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && !dir && bidx == 3'd4) |-> !full);
endmodule

// File: rtl/cardcmd_ctrl.sv
module cardcmd_ctrl
  import cardcmd_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int WPB_W     = 13,
  parameter int MAX_DELAY = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        crc_err,
  output logic        irq,
  output logic [7:0]  card_dout,
  input  logic [7:0]  card_din,
  output logic        card_strobe,
  output logic        card_wr,
  output logic        card_rst,
  output logic [1:0]  key_idx,
  output logic [31:0] seed_out
);
  logic [3:0]              size_code;
  logic [2:0]              dly;
  logic                    dir, ie, start, push, pop, busy, ready;
  logic [31:0]             blk, hold;
  logic [CMD_WORDS*32-1:0] cmd_flat;
  logic [WPB_W-1:0]        wpb;
  logic [CNT_W-1:0]        blocks_m1;

  assign card_wr   = dir;
  assign blocks_m1 = dir ? blk[16 +: CNT_W] : blk[0 +: CNT_W];

  cardcmd_regs #(.MAX_DELAY(MAX_DELAY)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .ready(ready), .crc_err(crc_err),
    .hold(hold), .rdata(reg_rdata), .size_code(size_code), .dly(dly),
    .dir(dir), .ie(ie), .crst(card_rst), .blk(blk), .cmd_flat(cmd_flat),
    .key_idx(key_idx), .seed_out(seed_out), .start(start), .push(push), .pop(pop)
  );

  cardcmd_sizedec #(.WPB_W(WPB_W)) u_size (.code(size_code), .wpb(wpb));

  cardcmd_engine #(.CNT_W(CNT_W), .WPB_W(WPB_W), .MAX_DELAY(MAX_DELAY)) u_eng (
    .clk(clk), .rst(rst), .start(start), .dir(dir), .dly(dly), .ie(ie),
    .wpb(wpb), .blocks_m1(blocks_m1), .cmd_flat(cmd_flat), .push(push),
    .pop(pop), .wdata(reg_wdata), .card_din(card_din), .busy(busy),
    .ready(ready), .hold(hold), .card_dout(card_dout),
    .card_strobe(card_strobe), .irq(irq)
  );
endmodule

// File: tb/tb_cardcmd_ctrl.sv
module tb_cardcmd_ctrl;
  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, crc_err = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, seed_out;
  logic        irq, card_strobe, card_wr, card_rst;
  logic [7:0]  card_dout, card_din;
  logic [1:0]  key_idx;

  int n_chk = 0, n_fail = 0, irq_cnt = 0, cyc = 0, scnt = 0, mark = 0;
  bit done = 0;
  logic [7:0] sbyte [64];
  int         scyc  [64];

  always #2 clk = ~clk;
  assign card_din = scnt[7:0];

  cardcmd_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .crc_err(crc_err), .irq(irq),
    .card_dout(card_dout), .card_din(card_din), .card_strobe(card_strobe),
    .card_wr(card_wr), .card_rst(card_rst), .key_idx(key_idx), .seed_out(seed_out)
  );

  always @(negedge clk) begin
    cyc++;
    if (irq) irq_cnt++;
    if (card_strobe) begin
      if (scnt - mark < 64) begin
        sbyte[scnt - mark] = card_dout;
        scyc[scnt - mark]  = cyc;
      end
      scnt++;
    end
  end

  // {size code, expected bytes per block}
  localparam logic [19:0] VEC [11] = '{
    {4'd0, 16'd0}, {4'd1, 16'd4}, {4'd2, 16'd16}, {4'd3, 16'd64},
    {4'd4, 16'd512}, {4'd5, 16'd1024}, {4'd6, 16'd2048}, {4'd7, 16'd4096},
    {4'd8, 16'd16384}, {4'd9, 16'd0}, {4'd15, 16'd0}};
  localparam logic [31:0] CMDW [4] = '{32'h11223344, 32'h55667788,
                                       32'h99AABBCC, 32'hDDEEFF00};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic go(input logic [31:0] ctrl);
    mark = scnt;
    wr(4'd0, ctrl);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do rd(4'd0, v); while (v[31]);
  endtask

  task automatic pop_word(output logic [31:0] d);
    logic [31:0] v;
    do rd(4'd0, v); while (!v[27]);
    rd(4'd8, d);
  endtask

  task automatic push_word(input logic [31:0] d);
    logic [31:0] v;
    do rd(4'd0, v); while (!v[27]);
    wr(4'd8, d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w;
    int i0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R14 reset state
    rd(4'd0, v);
    chk("R14 ctrl", v, 32'h0800_0000);
    chk("R14 pins", {card_strobe, irq, card_rst}, 0);

    // R12 CRC status bit 4
    crc_err = 1'b1; rd(4'd0, v); chk("R12 crc set", v[4], 1);
    crc_err = 1'b0; rd(4'd0, v); chk("R12 crc clear", v[4], 0);

    // R11 security latches
    wr(4'd3, 32'hA5A5_0001);
    wr(4'd2, 32'h0000_0204);
    @(negedge clk); chk("R11 key latched", key_idx, 2);
    wr(4'd2, 32'h0000_8100);
    @(negedge clk); chk("R11 key kept", key_idx, 2);
    chk("R11 seed latched", seed_out, 32'hA5A5_0001);
    wr(4'd3, 32'h1234_5678);
    wr(4'd2, 32'h0000_0300);
    @(negedge clk);
    chk("R11 seed kept", seed_out, 32'hA5A5_0001);
    chk("R11 key unchanged", key_idx, 2);

    // R1 command order, R8 zero size ends after command, R9 irq on
    for (int k = 0; k < 4; k++) wr(4'(4 + k), CMDW[k]);
    i0 = irq_cnt;
    go(32'hC000_0000);
    wait_idle();
    chk("R8 zero size byte count", scnt - mark, 16);
    for (int k = 0; k < 16; k++) begin
      chk("R1 command byte", sbyte[k], 8'(CMDW[k / 4] >> (24 - 8 * (k % 4))));
      chk("R1 back-to-back", scyc[k] - scyc[0], k);
    end
    chk("R9 one irq pulse", irq_cnt - i0, 1);
    rd(4'd0, v); chk("R8 idle ctrl", v, 32'h4800_0000);

    // R2 size code table, read direction, one block, irq off
    wr(4'd1, 32'h0000_0000);
    i0 = irq_cnt;
    for (int t = 0; t < 11; t++) begin
      go(32'h8000_0000 | (32'(VEC[t][19:16]) << 16));
      for (int k = 0; k < int'(VEC[t][15:0]) / 4; k++) pop_word(w);
      wait_idle();
      chk($sformatf("R2 code %0d bytes", VEC[t][19:16]), scnt - mark - 16,
          32'(VEC[t][15:0]));
    end
    chk("R9 no irq when disabled", irq_cnt - i0, 0);

    // R5 read data, R7 ready, R13 ignore while busy, R4 zero delay
    go(32'h8002_0000);
    rd(4'd0, v); chk("R7 busy not ready", v, 32'h8002_0000);
    wr(4'd0, 32'h6705_0000);
    rd(4'd0, v); chk("R13 ctrl frozen", v, 32'h8002_0000);
    for (int k = 0; k < 4; k++) begin
      pop_word(w);
      chk("R5 read word", w, {8'(mark + 17 + 4*k), 8'(mark + 18 + 4*k),
                              8'(mark + 19 + 4*k), 8'(mark + 20 + 4*k)});
    end
    wait_idle();
    chk("R4 zero delay gap", scyc[16] - scyc[15], 1);

    // R3 read blocks from low half
    wr(4'd1, {16'd2, 16'd1});
    go(32'h8001_0000);
    for (int k = 0; k < 2; k++) pop_word(w);
    wait_idle();
    chk("R3 read block count", scnt - mark - 16, 8);

    // R3 write blocks from high half, R6 byte order, R4 delay 3
    wr(4'd0, 32'h2301_0000);
    chk("R3 card_wr high", card_wr, 1);
    wr(4'd8, 32'hCAFE_F00D);
    go(32'hA301_0000);
    push_word(32'h0102_0304);
    push_word(32'hF1E2_D3C4);
    wait_idle();
    chk("R3 write block count", scnt - mark - 16, 12);
    chk("R4 delay 3 gap", scyc[16] - scyc[15], 4);
    chk("R6 write word 0", {sbyte[16], sbyte[17], sbyte[18], sbyte[19]}, 32'hCAFE_F00D);
    chk("R6 write word 1", {sbyte[20], sbyte[21], sbyte[22], sbyte[23]}, 32'h0102_0304);
    chk("R6 write word 2", {sbyte[24], sbyte[25], sbyte[26], sbyte[27]}, 32'hF1E2_D3C4);

    // R4 clamp of delay above 5
    wr(4'd0, 32'h0700_0000);
    rd(4'd0, v); chk("R4 delay clamp", v[26:24], 5);

    // R10 sticky card reset
    wr(4'd0, 32'h1000_0000);
    @(negedge clk); chk("R10 reset raised", card_rst, 1);
    wr(4'd0, 32'h0000_0000);
    @(negedge clk); chk("R10 reset held", card_rst, 1);
    rd(4'd0, v); chk("R10 reset bit read", v[28], 1);
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R10 cleared by reset", card_rst, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule